// File: doc/BRIEF.md
# Sticky Interrupt Status Aggregator

This block collects the completion and fault events of a DMA-driven accelerator and presents them to software as one status word and one enable word behind a small register port. Three single-cycle event pulses arrive from the datapath: a bus access fault, the end of a packet, and the end of a descriptor. Each pulse sets a flag that stays set until software clears it. The flags are visible whatever the enables hold, so software can poll them instead of taking interrupts.

The lowest status bit is a summary that reads as the OR of the three event flags. Software clears an event by writing a 1 to that event's bit and a 1 to the summary bit in the same write. A 1 on only one of the two clears nothing. All sources drive one interrupt line. A source reaches that line only when its own enable bit is set and the summary enable bit is also set. The interrupt line can be combinational from the registers, or retimed through one flop, chosen by a parameter.

Top module: `irq_status_agg`

## Requirements
- R1: After reset, the status word and the enable word both read as zero and `irq` is low.
- R2: A pulse on `evt_acc_err`, `evt_pkt_done` or `evt_desc_done` sets status bit 3, 2 or 1 respectively on the next clock edge, whatever the enable word holds.
- R3: Status bit 0 always reads as the OR of status bits 3:1. It reads 0 when all three are clear.
- R4: A status write clears event bit k (k in 1..3) only when both wr_data[k] and wr_data[0] are 1. A 1 in only one of those two positions leaves the flag unchanged. Flags not cleared this way stay set.
- R5: When an event pulse and a clearing write for the same bit fall in the same cycle, the bit stays set.
- R6: The enable word uses the same bit positions as the status word: bit 3 access fault, bit 2 packet, bit 1 descriptor, bit 0 summary. A write stores wr_data[3:0], and a read returns it.
- R7: `irq` is high exactly when enable bit 0 is set and at least one status bit k in 1..3 is set with enable bit k also set. With IRQ_REG = 0 this holds in the same cycle as the register state. With IRQ_REG = 1 it holds one cycle later.
- R8: Bits 31:4 of both words read as zero, and writes to them have no effect.
- R9: An address that matches neither word (status at 0, enable at 4) reads as zero, and a write to it changes neither word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_acc_err | input | 1 | Bus access fault event pulse |
| evt_pkt_done | input | 1 | Packet completion event pulse |
| evt_desc_done | input | 1 | Descriptor completion event pulse |
| reg_addr | input | ADDR_W (4) | Register address (status 0, enable 4) |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Read data for `reg_addr`, combinational |
| irq | output | 1 | Shared interrupt line |

## Verification
The state that can go wrong here is a sticky flag or an enable bit, and each one is visible at the ports one edge after the event or write that should have changed it. A flag that is lost or wrongly cleared shows on the next status read, in bit 0 as well as in its own bit. It also shows on `irq` as soon as the matching enables are set. Stuck enable bits show on readback, and in the same cycle as a mismatch between `irq` and the enabled flags. The bench therefore reads back after every stimulus. It drives the collision cases of a clear and an event in the same cycle, on the same bit and on different bits.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
   localparam int unsigned SRC_N    = 3;
   localparam int unsigned FLAG_W   = SRC_N + 1;
   localparam int unsigned IDX_SUM  = 0;
   localparam int unsigned IDX_DESC = 1;
   localparam int unsigned IDX_PKT  = 2;
   localparam int unsigned IDX_ACC  = 3;
   typedef logic [SRC_N-1:0]  src_vec_t;
   typedef logic [FLAG_W-1:0] flag_word_t;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
   parameter int unsigned N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_vec,
   input  logic [N-1:0] clr_vec,
   output logic [N-1:0] flags
);
   if (N < 1) begin : g_bad_n
      $error("irq_flag_bank: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_cell
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            flags[i] <= 1'b0;
         else if (set_vec[i])
            flags[i] <= 1'b1;
         else if (clr_vec[i])
            flags[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
   import irq_agg_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned STS_ADDR = 0,
   parameter int unsigned EN_ADDR  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  flag_word_t        sts_word,
   output src_vec_t          clr_vec,
   output flag_word_t        en_q,
   output logic [DATA_W-1:0] reg_rdata
);
   localparam logic [ADDR_W-1:0] STS_A = ADDR_W'(STS_ADDR);
   localparam logic [ADDR_W-1:0] EN_A  = ADDR_W'(EN_ADDR);

   if (DATA_W < FLAG_W) begin : g_bad_w
      $error("irq_reg_port: DATA_W too narrow for the flag word");
   end
   if (STS_ADDR == EN_ADDR) begin : g_bad_a
      $error("irq_reg_port: status and enable addresses collide");
   end
   if (STS_ADDR >= (1 << ADDR_W) || EN_ADDR >= (1 << ADDR_W)) begin : g_bad_r
      $error("irq_reg_port: address does not fit ADDR_W");
   end

   logic sel_sts, sel_en;
   assign sel_sts = (reg_addr == STS_A);
   assign sel_en  = (reg_addr == EN_A);

   // clearing needs the source bit and the summary bit together
   always_comb begin
      for (int i = 0; i < SRC_N; i++)
         clr_vec[i] = reg_wr & sel_sts & reg_wdata[i+1] & reg_wdata[IDX_SUM];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         en_q <= '0;
      else if (reg_wr && sel_en)
         en_q <= reg_wdata[FLAG_W-1:0];
   end

   if (DATA_W > FLAG_W) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^reg_wdata[DATA_W-1:FLAG_W];
   end

   always_comb begin
      reg_rdata = '0;
      if (sel_sts)
         reg_rdata[FLAG_W-1:0] = sts_word;
      else if (sel_en)
         reg_rdata[FLAG_W-1:0] = en_q;
   end
endmodule

// File: rtl/irq_out_gate.sv
module irq_out_gate
   import irq_agg_pkg::*;
#(
   parameter bit IRQ_REG = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  src_vec_t   flags,
   input  flag_word_t en_q,
   output logic       irq
);
   logic want;
   assign want = en_q[IDX_SUM] & (|(flags & en_q[FLAG_W-1:1]));

   if (IRQ_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= want;
      end
   end else begin : g_comb
      assign irq = want;
   end
endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
   import irq_agg_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned STS_ADDR = 0,
   parameter int unsigned EN_ADDR  = 4,
   parameter bit          IRQ_REG  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt_acc_err,
   input  logic              evt_pkt_done,
   input  logic              evt_desc_done,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq
);
   src_vec_t   set_vec, clr_vec, flags;
   flag_word_t en_q, sts_word;

   // source order follows status bits 3..1
   assign set_vec  = {evt_acc_err, evt_pkt_done, evt_desc_done};
   assign sts_word = {flags, |flags};

   irq_flag_bank #(.N(SRC_N)) flag_i (
      .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec), .flags(flags)
   );

   irq_reg_port #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .STS_ADDR(STS_ADDR), .EN_ADDR(EN_ADDR)
   ) port_i (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .sts_word(sts_word), .clr_vec(clr_vec),
      .en_q(en_q), .reg_rdata(reg_rdata)
   );

   irq_out_gate #(.IRQ_REG(IRQ_REG)) gate_i (
      .clk(clk), .rst_n(rst_n), .flags(flags), .en_q(en_q), .irq(irq)
   );
endmodule

// File: rtl/irq_status_agg_chk.sv
module irq_status_agg_chk
   import irq_agg_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned STS_ADDR = 0,
   parameter int unsigned EN_ADDR  = 4,
   parameter bit          IRQ_REG  = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input src_vec_t          set_vec,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              reg_wr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic [DATA_W-1:0] reg_rdata,
   input logic              irq,
   input src_vec_t          flags,
   input flag_word_t        en_q
);
   src_vec_t wmask;
   logic     want;
   assign wmask = (reg_wr && reg_addr == ADDR_W'(STS_ADDR) && reg_wdata[0])
                  ? reg_wdata[SRC_N:1] : '0;
   assign want  = en_q[0] && ((flags & en_q[SRC_N:1]) != '0);

   AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (set_vec != '0) |=> ((flags & $past(set_vec)) == $past(set_vec))); // R2

   AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((flags & $past(flags & ~wmask)) == $past(flags & ~wmask))); // R4

   AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      ((wmask & ~set_vec) != '0) |=> ((flags & $past(wmask & ~set_vec)) == '0)); // R4

   AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      ((wmask & set_vec) != '0) |=> ((flags & $past(wmask & set_vec)) == $past(wmask & set_vec))); // R5

   AST_SUMMARY_OR: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == ADDR_W'(STS_ADDR)) |-> (reg_rdata[0] == (reg_rdata[SRC_N:1] != '0))); // R3

   AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[DATA_W-1:FLAG_W] == '0); // R8

   if (IRQ_REG) begin : g_irq_reg
      AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> (irq == $past(want))); // R7
   end else begin : g_irq_comb
      AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
         irq == want); // R7
   end
endmodule

bind irq_status_agg irq_status_agg_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .STS_ADDR(STS_ADDR),
   .EN_ADDR(EN_ADDR), .IRQ_REG(IRQ_REG)
) chk_i (
   .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .reg_addr(reg_addr),
   .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
   .irq(irq), .flags(flags), .en_q(en_q)
);

// File: tb/irq_status_agg_tb.sv
module irq_status_agg_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        evt_acc_err = 1'b0, evt_pkt_done = 1'b0, evt_desc_done = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq;
   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   localparam logic [3:0] A_STS = 4'd0, A_EN = 4'd4, A_NONE = 4'd8;
   localparam logic [2:0] E_ACC = 3'b100, E_PKT = 3'b010, E_DESC = 3'b001;

   always #4 clk = ~clk;

   irq_status_agg dut_i (
      .clk(clk), .rst_n(rst_n), .evt_acc_err(evt_acc_err), .evt_pkt_done(evt_pkt_done),
      .evt_desc_done(evt_desc_done), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   // one clock with optional write and event vector {acc,pkt,desc}
   task automatic cyc(input bit w, input logic [3:0] a, input logic [31:0] d, input logic [2:0] e);
      @(negedge clk);
      reg_wr = w; reg_addr = a; reg_wdata = d;
      {evt_acc_err, evt_pkt_done, evt_desc_done} = e;
      @(negedge clk);
      reg_wr = 1'b0; {evt_acc_err, evt_pkt_done, evt_desc_done} = 3'b000;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] v);
      reg_addr = a; #1; v = reg_rdata;
   endtask

   task automatic t_reset;
      logic [31:0] v;
      rd(A_STS, v); chk("R1 status after reset", v, 32'h0);
      rd(A_EN, v);  chk("R1 enable after reset", v, 32'h0);
      chk("R1 irq after reset", {31'b0, irq}, 32'h0);
   endtask

   task automatic t_events;
      logic [31:0] v;
      cyc(1'b0, A_STS, '0, E_PKT);
      rd(A_STS, v); chk("R2 packet sets bit2, R3 summary", v, 32'h5);
      cyc(1'b0, A_STS, '0, E_DESC);
      rd(A_STS, v); chk("R2 descriptor sets bit1", v, 32'h7);
      cyc(1'b0, A_STS, '0, E_ACC);
      rd(A_STS, v); chk("R2 access fault sets bit3", v, 32'hF);
      chk("R2 irq stays low with enables off", {31'b0, irq}, 32'h0);
   endtask

   task automatic t_clear;
      logic [31:0] v;
      cyc(1'b1, A_STS, 32'h8, 3'b000);
      rd(A_STS, v); chk("R4 source bit alone clears nothing", v, 32'hF);
      cyc(1'b1, A_STS, 32'h1, 3'b000);
      rd(A_STS, v); chk("R4 summary bit alone clears nothing", v, 32'hF);
      cyc(1'b1, A_STS, 32'h9, 3'b000);
      rd(A_STS, v); chk("R4 clear of access fault", v, 32'h7);
      cyc(1'b1, A_STS, 32'h7, 3'b000);
      rd(A_STS, v); chk("R3 summary drops when all clear", v, 32'h0);
   endtask

   task automatic t_collide;
      logic [31:0] v;
      cyc(1'b0, A_STS, '0, E_PKT);
      cyc(1'b1, A_STS, 32'h5, E_PKT);
      rd(A_STS, v); chk("R5 event beats clear on same bit", v, 32'h5);
      cyc(1'b0, A_STS, '0, E_DESC);
      cyc(1'b1, A_STS, 32'h7, E_DESC);
      rd(A_STS, v); chk("R5 descriptor held, packet cleared", v, 32'h3);
      cyc(1'b1, A_STS, 32'h3, 3'b000);
      rd(A_STS, v); chk("R4 final clear", v, 32'h0);
   endtask

   task automatic t_enable;
      logic [31:0] v;
      cyc(1'b1, A_EN, 32'hFFFF_FFFF, 3'b000);
      rd(A_EN, v); chk("R6 R8 enable keeps bits 3:0 only", v, 32'hF);
      cyc(1'b1, A_EN, 32'hA5A5_A5A5, 3'b000);
      rd(A_EN, v); chk("R6 enable pattern readback", v, 32'h5);
   endtask

   task automatic t_irq;
      logic [31:0] v;
      cyc(1'b1, A_EN, 32'h4, 3'b000);
      cyc(1'b0, A_STS, '0, E_PKT);
      chk("R7 no irq without summary enable", {31'b0, irq}, 32'h0);
      cyc(1'b1, A_EN, 32'h5, 3'b000);
      chk("R7 irq with packet and summary enabled", {31'b0, irq}, 32'h1);
      cyc(1'b1, A_EN, 32'h9, 3'b000);
      chk("R7 no irq when set flag is not enabled", {31'b0, irq}, 32'h0);
      cyc(1'b0, A_STS, '0, E_ACC);
      chk("R7 access fault drives shared line", {31'b0, irq}, 32'h1);
      cyc(1'b1, A_STS, 32'h9, 3'b000);
      chk("R7 irq drops after clear", {31'b0, irq}, 32'h0);
      rd(A_STS, v); chk("R2 packet flag still visible", v, 32'h5);
   endtask

   task automatic t_upper_unmapped;
      logic [31:0] v;
      cyc(1'b1, A_STS, 32'hFFFF_FFF0, 3'b000);
      rd(A_STS, v); chk("R8 upper status bits ignore writes", v, 32'h5);
      cyc(1'b1, A_NONE, 32'hFFFF_FFFF, 3'b000);
      rd(A_STS, v);  chk("R9 unmapped write leaves status", v, 32'h5);
      rd(A_EN, v);   chk("R9 unmapped write leaves enable", v, 32'h9);
      rd(A_NONE, v); chk("R9 unmapped read is zero", v, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset;
      t_events;
      t_clear;
      t_collide;
      t_enable;
      t_irq;
      t_upper_unmapped;
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule